// File: doc/BRIEF.md
# PS/2 Host Command Transmitter

This block sends one command byte from a host controller to a PS/2 device. The two shared lines are open-drain, so the block never drives them high. It only asserts an active-high pull-down enable for each line. The clock and data levels it reads back have already been synchronized to the system clock. A free-running one-microsecond tick times the bus inhibit.

A transfer begins with a one-cycle start strobe that carries the byte. The block holds the clock line low for a set number of microseconds. It then pulls data low as the start bit and lets the clock go, and from that point the device drives the clock. Nine bits follow, least significant first: the eight data bits and an odd-parity bit. Each one is placed on the data line just after the device pulls the clock low. After the parity bit the block lets data go on the next clock fall. It then waits for the device's acknowledge, which is data falling and after that clock falling, and ends the transfer. On the final cycle it pulses done, drops busy and sends a one-cycle restart request to the neighbouring receiver. That request restarts the receiver's inactivity timer and discards any half-received bit.

Top module: `ps2_host_tx`

## Requirements
- R1: Right after reset, clk_pd_o, dat_pd_o, busy_o, done_o and rx_restart_o are all 0.
- R2: A start_i pulse while busy_o is 0 makes clk_pd_o and busy_o 1 on the next cycle. clk_pd_o then stays 1 for exactly HOLD_US clock edges on which tick_us_i is high.
- R3: The edge that counts the last hold tick sets dat_pd_o to 1, which is the start bit. clk_pd_o stays 1 for one more cycle and then goes to 0.
- R4: After the clock is released, each falling edge of ps2_clk_i places the next frame bit. One cycle after the edge is sampled, dat_pd_o becomes the inverse of that bit: 1 pulls the line low for a 0. Data bits go out least significant first, and the block moves on to the next bit only after a rising edge of ps2_clk_i.
- R5: The ninth bit is odd parity: 1 when the data byte holds an even number of ones.
- R6: After the rising clock edge that follows the parity bit, the next falling edge of ps2_clk_i sets dat_pd_o to 0.
- R7: After the data release, a falling edge of ps2_dat_i followed by a falling edge of ps2_clk_i ends the transfer. On the cycle after that clock fall, done_o and rx_restart_o are 1 for exactly one cycle and busy_o is 0.
- R8: start_i is ignored while busy_o is 1. The byte already captured is the one that goes out on the bus.
- R9: Both pull-down enables are 0 whenever busy_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to send cmd_i |
| cmd_i | input | 8 | Byte to send, captured with start_i |
| ps2_clk_i | input | 1 | Synchronized PS/2 clock level |
| ps2_dat_i | input | 1 | Synchronized PS/2 data level |
| tick_us_i | input | 1 | One-cycle pulse every microsecond |
| clk_pd_o | output | 1 | Pull PS/2 clock low |
| dat_pd_o | output | 1 | Pull PS/2 data low |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse when the acknowledge completes |
| rx_restart_o | output | 1 | One-cycle request to restart the receiver's timer and clear its pending bit |

## Verification
Every output is registered. Each one changes on the edge that first samples the causing input, so it is due one cycle after an input change: one cycle after start_i, after the final hold tick, after each clock fall and after the acknowledge. The only exception is the clock release, which comes one cycle after the start bit appears. The bench changes inputs on falling clock edges. A behavioural model advances on each rising edge from the same inputs, and the outputs are compared with it at the next falling edge. An emulated device records the line level at each rising clock edge it makes, so the sent bits and parity are also checked as a whole frame.

// File: rtl/ps2tx_pkg.sv
// Shared types for the PS/2 host transmitter.
// Assumes: one state register in the top sequencer.
package ps2tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,     // bus untouched
        ST_INHIBIT,  // clock held low
        ST_STARTBIT, // data low, clock still low
        ST_BIT_LOW,  // waiting for device clock fall
        ST_BIT_HIGH, // waiting for device clock rise
        ST_DAT_REL,  // waiting for clock fall to free data
        ST_ACK_DAT,  // waiting for device to pull data
        ST_ACK_CLK   // waiting for final clock fall
    } tx_state_e;

endpackage

// File: rtl/ps2tx_edge.sv
// Edge detector for one already-synchronized line.
// Assumes: the line idles high, so the history register resets to 1.
module ps2tx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic fall_o,
    output logic rise_o
);
    logic prev_q;

    // Keep last cycle's level
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= line_i;
    end

    assign fall_o = prev_q & ~line_i;
    assign rise_o = ~prev_q & line_i;
endmodule

// File: rtl/ps2tx_hold_timer.sv
// Counts microsecond ticks during the bus inhibit.
// Assumes: clr_i comes at least one cycle before run_i.
module ps2tx_hold_timer #(
    parameter int HOLD_US = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic run_i,
    input  logic tick_i,
    output logic expire_o
);
    localparam int CW = $clog2(HOLD_US + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_US - 1);

    logic [CW-1:0] cnt_q;

    // Count ticks while running
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)        cnt_q <= '0;
        else if (run_i && tick_i)   cnt_q <= cnt_q + 1'b1;
    end

    assign expire_o = run_i && tick_i && (cnt_q == LAST);
endmodule

// File: rtl/ps2tx_frame_shift.sv
// Holds the data byte plus odd parity and hands them out LSB first.
// Assumes: load_i and shift_i are never high together.
module ps2tx_frame_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              shift_i,
    output logic              bit_o,
    output logic              last_o
);
    localparam int FRAME_W = DATA_W + 1;
    localparam int NW      = $clog2(FRAME_W + 1);

    logic [FRAME_W-1:0] sh_q;
    logic [NW-1:0]      sent_q;

    // Load byte with parity, then shift one bit per request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            sent_q <= '0;
        end else if (load_i) begin
            sh_q   <= {~^data_i, data_i};
            sent_q <= '0;
        end else if (shift_i) begin
            sh_q   <= {1'b0, sh_q[FRAME_W-1:1]};
            sent_q <= sent_q + 1'b1;
        end
    end

    assign bit_o  = sh_q[0];
    assign last_o = (sent_q == NW'(FRAME_W));
endmodule

// File: rtl/ps2_host_tx.sv
// PS/2 host-to-device command transmitter.
// Assumes: ps2 inputs are synchronized; tick_us_i is one cycle wide.
// Drives lines only through pull-down enables.
module ps2_host_tx #(
    parameter int HOLD_US = 100,
    parameter int DATA_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] cmd_i,
    input  logic              ps2_clk_i,
    input  logic              ps2_dat_i,
    input  logic              tick_us_i,
    output logic              clk_pd_o,
    output logic              dat_pd_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              rx_restart_o
);
    import ps2tx_pkg::*;

    tx_state_e st_q;
    logic clk_fall, clk_rise, dat_fall, dat_rise_unused;
    logic hold_done, cur_bit, frame_last;
    logic do_load, do_shift;

    ps2tx_edge u_clk_edge (.clk(clk), .rst_n(rst_n), .line_i(ps2_clk_i),
                           .fall_o(clk_fall), .rise_o(clk_rise));
    ps2tx_edge u_dat_edge (.clk(clk), .rst_n(rst_n), .line_i(ps2_dat_i),
                           .fall_o(dat_fall), .rise_o(dat_rise_unused));

    ps2tx_hold_timer #(.HOLD_US(HOLD_US)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr_i(do_load),
        .run_i(st_q == ST_INHIBIT), .tick_i(tick_us_i), .expire_o(hold_done));

    assign do_load  = (st_q == ST_IDLE) && start_i;
    assign do_shift = (st_q == ST_BIT_LOW) && clk_fall;

    ps2tx_frame_shift #(.DATA_W(DATA_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .load_i(do_load), .data_i(cmd_i),
        .shift_i(do_shift), .bit_o(cur_bit), .last_o(frame_last));

    // Sequencer and registered line controls
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= ST_IDLE;
            clk_pd_o     <= 1'b0;
            dat_pd_o     <= 1'b0;
            busy_o       <= 1'b0;
            done_o       <= 1'b0;
            rx_restart_o <= 1'b0;
        end else begin
            done_o       <= 1'b0;
            rx_restart_o <= 1'b0;
            unique case (st_q)
                ST_IDLE: if (start_i) begin
                    st_q     <= ST_INHIBIT;
                    clk_pd_o <= 1'b1;
                    busy_o   <= 1'b1;
                end
                ST_INHIBIT: if (hold_done) begin
                    st_q     <= ST_STARTBIT;
                    dat_pd_o <= 1'b1;
                end
                ST_STARTBIT: begin
                    st_q     <= ST_BIT_LOW;
                    clk_pd_o <= 1'b0;
                end
                ST_BIT_LOW: if (clk_fall) begin
                    st_q     <= ST_BIT_HIGH;
                    dat_pd_o <= ~cur_bit;
                end
                ST_BIT_HIGH: if (clk_rise) begin
                    st_q <= frame_last ? ST_DAT_REL : ST_BIT_LOW;
                end
                ST_DAT_REL: if (clk_fall) begin
                    st_q     <= ST_ACK_DAT;
                    dat_pd_o <= 1'b0;
                end
                ST_ACK_DAT: if (dat_fall) st_q <= ST_ACK_CLK;
                ST_ACK_CLK: if (clk_fall) begin
                    st_q         <= ST_IDLE;
                    busy_o       <= 1'b0;
                    done_o       <= 1'b1;
                    rx_restart_o <= 1'b1;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ps2_host_tx_chk.sv
// Port-level properties of the PS/2 host transmitter, bound to the top.
module ps2_host_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic clk_pd_o,
    input logic dat_pd_o,
    input logic busy_o,
    input logic done_o,
    input logic rx_restart_o
);
    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!clk_pd_o && !dat_pd_o));

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && clk_pd_o));

    // R3
    release_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $fell(clk_pd_o)) |-> (dat_pd_o && $past(dat_pd_o)));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7
    done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o) && rx_restart_o));
endmodule

bind ps2_host_tx ps2_host_tx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .clk_pd_o(clk_pd_o),
    .dat_pd_o(dat_pd_o), .busy_o(busy_o), .done_o(done_o),
    .rx_restart_o(rx_restart_o));

// File: tb/tb_ps2_host_tx.sv
`timescale 1ns/1ps
// Bench: emulated device, behavioural per-cycle model, frame checks.
module tb_ps2_host_tx;
    localparam int HOLD = 100;
    localparam int HALF = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [7:0] cmd_i = '0;
    logic tick_us_i = 1'b0;
    logic dev_clk = 1'b1, dev_dat = 1'b1;
    logic ps2_clk_i, ps2_dat_i;
    logic clk_pd_o, dat_pd_o, busy_o, done_o, rx_restart_o;

    int checks = 0, fails = 0;
    int tick_div = 0;
    int hold_seen = 0;

    assign ps2_clk_i = dev_clk & ~clk_pd_o;
    assign ps2_dat_i = dev_dat & ~dat_pd_o;

    ps2_host_tx #(.HOLD_US(HOLD), .DATA_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_i(cmd_i),
        .ps2_clk_i(ps2_clk_i), .ps2_dat_i(ps2_dat_i), .tick_us_i(tick_us_i),
        .clk_pd_o(clk_pd_o), .dat_pd_o(dat_pd_o), .busy_o(busy_o),
        .done_o(done_o), .rx_restart_o(rx_restart_o));

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Microsecond tick: one cycle in four, driven away from the edge
    always @(negedge clk) begin
        tick_div  = (tick_div + 1) % 4;
        tick_us_i <= (tick_div == 0);
    end

    // Behavioural model of expected outputs
    int  mph = 0, mt = 0, mi = 0;
    logic [7:0] mbyte = '0;
    logic mpc = 1'b1, mpd = 1'b1;
    logic e_cpd = 0, e_dpd = 0, e_busy = 0, e_done = 0, e_rst = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            mph = 0; e_cpd = 0; e_dpd = 0; e_busy = 0; e_done = 0; e_rst = 0;
            mpc = 1; mpd = 1;
        end else begin
            logic fc, rc, fd;
            fc = mpc & ~ps2_clk_i;
            rc = ~mpc & ps2_clk_i;
            fd = mpd & ~ps2_dat_i;
            e_done = 0; e_rst = 0;
            case (mph)
                0: if (start_i) begin mph = 1; e_cpd = 1; e_busy = 1; mbyte = cmd_i; mt = 0; end
                1: if (tick_us_i) begin mt++; if (mt == HOLD) begin mph = 2; e_dpd = 1; end end
                2: begin e_cpd = 0; mph = 3; mi = 0; end
                3: if (fc) begin
                       e_dpd = (mi < 8) ? ~mbyte[mi] : (^mbyte);
                       mi++; mph = 4;
                   end
                4: if (rc) mph = (mi == 9) ? 5 : 3;
                5: if (fc) begin e_dpd = 0; mph = 6; end
                6: if (fd) mph = 7;
                7: if (fc) begin e_done = 1; e_rst = 1; e_busy = 0; mph = 0; end
                default: mph = 0;
            endcase
            mpc = ps2_clk_i; mpd = ps2_dat_i;
        end
        if (rst_n && clk_pd_o && !dat_pd_o && tick_us_i) hold_seen++;
    end

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(clk_pd_o == e_cpd, "R2/R3 clk_pd", clk_pd_o, e_cpd);
            chk(dat_pd_o == e_dpd, "R4/R6 dat_pd", dat_pd_o, e_dpd);
            chk(busy_o == e_busy, "R7 busy", busy_o, e_busy);
            chk(done_o == e_done, "R7 done", done_o, e_done);
            chk(rx_restart_o == e_rst, "R7 rx_restart", rx_restart_o, e_rst);
            if (!busy_o) chk(!clk_pd_o && !dat_pd_o, "R9 idle lines", {clk_pd_o, dat_pd_o}, 0);
        end
    end

    task automatic send_start(input logic [7:0] b);
        @(negedge clk);
        start_i = 1'b1; cmd_i = b;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Emulated device: clocks the frame in and acknowledges
    task automatic device_frame(output logic [8:0] got);
        do @(negedge clk); while (!(busy_o && !clk_pd_o));
        repeat (5) @(negedge clk);
        for (int b = 0; b < 9; b++) begin
            dev_clk = 1'b0; repeat (HALF) @(negedge clk);
            got[b] = ps2_dat_i;
            dev_clk = 1'b1; repeat (HALF) @(negedge clk);
        end
        dev_clk = 1'b0; repeat (HALF) @(negedge clk);
        chk(dat_pd_o == 1'b0, "R6 data freed", dat_pd_o, 0);
        dev_clk = 1'b1; repeat (HALF) @(negedge clk);
        dev_dat = 1'b0; repeat (HALF) @(negedge clk);
        chk(busy_o == 1'b1, "R7 busy before ack clock", busy_o, 1);
        dev_clk = 1'b0; @(negedge clk);
        chk(done_o && rx_restart_o && !busy_o, "R7 done pulse", {done_o, rx_restart_o, busy_o}, 3'b110);
        @(negedge clk);
        chk(!done_o, "R7 done one cycle", done_o, 0);
        repeat (HALF) @(negedge clk);
        dev_clk = 1'b1; dev_dat = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic run_byte(input logic [7:0] b, input bit poke_busy);
        logic [8:0] got;
        hold_seen = 0;
        send_start(b);
        chk(busy_o && clk_pd_o, "R2 start accepted", {busy_o, clk_pd_o}, 3);
        if (poke_busy) begin
            repeat (20) @(negedge clk);
            send_start(~b);
        end
        device_frame(got);
        chk(hold_seen == HOLD, "R2 hold ticks", hold_seen, HOLD);
        chk(got[7:0] == b, poke_busy ? "R8 byte kept" : "R4 data bits", got[7:0], b);
        chk(got[8] == ~^b, "R5 odd parity", got[8], ~^b);
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk({clk_pd_o, dat_pd_o, busy_o, done_o, rx_restart_o} == 5'b0, "R1 reset", 
            {clk_pd_o, dat_pd_o, busy_o, done_o, rx_restart_o}, 0);
        run_byte(8'hA5, 1'b0);
        run_byte(8'h00, 1'b0);
        run_byte(8'hFF, 1'b0);
        run_byte(8'h01, 1'b0);
        run_byte(8'hED, 1'b1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule